// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block derives the bus timing of an I2C controller from its system clock. A 6-bit rate code selects one of 64 fixed division ratios, spread irregularly between 22 and 3840. From the selected ratio, two free-running counters produce the controller's timing strobes. The first is a sample tick at the prescaled rate, which is the only rate at which the controller looks at SCL and SDA. The second is a half-period strobe that paces each SCL level.

Software writes a new code into a pending register at any time, and the code register keeps its value when the module enable drops. The code in force, and with it the divider, changes only at a bus START or repeated START. The one exception is when no transfer is active, in which case the pending code is adopted at the next clock edge. A change of divider restarts both counters, so the first strobe after a change comes a full new period later.

Top module: `i2c_rate_prescaler`

## Requirements
- R1: After reset the pending and active codes are 0x00, `active_div` reads 30 and neither strobe is high until the counters have run.
- R2: `active_div` equals the divider of the active code. Codes 0x00..0x0F give 30,32,36,42,48,52,60,72,80,88,104,128,144,160,192,240. Codes 0x20..0x2F give 22,24,26,28,32,36,40,44,48,56,64,72,80,96,112,128. For codes 0x10..0x1F, write the code as 0x10+4s+m; the divider is {9,10,12,15}[m] shifted left by 5+s. For codes 0x30..0x3F, written as 0x30+4s+m, the divider is (5+m) shifted left by 5+s.
- R3: A pulse on `cfg_we` loads `cfg_code` into the pending register at that edge. The pending and active codes are cleared only by `rst_n`, never by `blk_en` going low.
- R4: With `blk_en` high and the divider unchanged, `sample_tick` is high for one cycle in every D cycles.
- R5: With `blk_en` high and the divider unchanged, `scl_strobe` is high for one cycle in every floor(D/2) cycles, and it coincides with every `sample_tick`.
- R6: While `xfer_busy` is high and `bus_start` is low, writes to the code leave `active_div` and the strobe period unchanged.
- R7: The pending code becomes active at the edge where `bus_start` is high, or at any edge where `xfer_busy` is low.
- R8: While `blk_en` is low, both counters are held at zero and neither strobe fires. After `blk_en` rises, the first `sample_tick` comes in the D-th cycle.
- R9: When adoption changes the divider, both counters restart at that edge. The first `sample_tick` then comes in the D-th cycle after the edge, measured with the new D.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en | input | 1 | Module enable; low holds the counters at zero |
| cfg_we | input | 1 | Write strobe for the rate code |
| cfg_code | input | 6 | Rate code to be written |
| bus_start | input | 1 | One-cycle pulse at a START or repeated START |
| xfer_busy | input | 1 | High while a byte transfer is in progress |
| sample_tick | output | 1 | Bus-sample enable at the prescaled rate |
| scl_strobe | output | 1 | SCL half-period strobe |
| active_div | output | 12 | Divider currently in force |

## Verification
The assertions assume that `bus_start` and `xfer_busy` come from a protocol engine that changes them only between clock edges. They also assume that `rst_n` is held low through the first edge. The strobe-alignment properties rely on every divider in the table being even and at least 22. The stimulus uses only the defined codes, changes every input a few nanoseconds after a rising edge, and pulses `bus_start` for one cycle at a time, so all input patterns stay within these limits.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;

  localparam int CODE_W = 6;
  localparam int DIV_W  = 12;
  localparam int NUM_STROBES = 2;

  typedef logic [CODE_W-1:0] rate_code_t;
  typedef logic [DIV_W-1:0]  div_t;

  // Lower quadrant: irregular short dividers
  function automatic div_t low_quad_div(input logic [3:0] idx);
    case (idx)
      4'h0: low_quad_div = 12'd30;
      4'h1: low_quad_div = 12'd32;
      4'h2: low_quad_div = 12'd36;
      4'h3: low_quad_div = 12'd42;
      4'h4: low_quad_div = 12'd48;
      4'h5: low_quad_div = 12'd52;
      4'h6: low_quad_div = 12'd60;
      4'h7: low_quad_div = 12'd72;
      4'h8: low_quad_div = 12'd80;
      4'h9: low_quad_div = 12'd88;
      4'hA: low_quad_div = 12'd104;
      4'hB: low_quad_div = 12'd128;
      4'hC: low_quad_div = 12'd144;
      4'hD: low_quad_div = 12'd160;
      4'hE: low_quad_div = 12'd192;
      default: low_quad_div = 12'd240;
    endcase
  endfunction

  // Third quadrant: the fastest rates
  function automatic div_t fast_quad_div(input logic [3:0] idx);
    case (idx)
      4'h0: fast_quad_div = 12'd22;
      4'h1: fast_quad_div = 12'd24;
      4'h2: fast_quad_div = 12'd26;
      4'h3: fast_quad_div = 12'd28;
      4'h4: fast_quad_div = 12'd32;
      4'h5: fast_quad_div = 12'd36;
      4'h6: fast_quad_div = 12'd40;
      4'h7: fast_quad_div = 12'd44;
      4'h8: fast_quad_div = 12'd48;
      4'h9: fast_quad_div = 12'd56;
      4'hA: fast_quad_div = 12'd64;
      4'hB: fast_quad_div = 12'd72;
      4'hC: fast_quad_div = 12'd80;
      4'hD: fast_quad_div = 12'd96;
      4'hE: fast_quad_div = 12'd112;
      default: fast_quad_div = 12'd128;
    endcase
  endfunction

  // Second quadrant: mantissa {9,10,12,15} times a power of two
  function automatic div_t slow_quad_div(input logic [3:0] idx);
    div_t mant;
    case (idx[1:0])
      2'd0: mant = 12'd9;
      2'd1: mant = 12'd10;
      2'd2: mant = 12'd12;
      default: mant = 12'd15;
    endcase
    slow_quad_div = mant << (5 + int'(idx[3:2]));
  endfunction

  // Top quadrant: mantissa 5..8 times a power of two
  function automatic div_t mid_quad_div(input logic [3:0] idx);
    div_t mant;
    mant = 12'd5 + div_t'(idx[1:0]);
    mid_quad_div = mant << (5 + int'(idx[3:2]));
  endfunction

  function automatic div_t code_to_div(input rate_code_t code);
    case (code[5:4])
      2'b00:   code_to_div = low_quad_div(code[3:0]);
      2'b01:   code_to_div = slow_quad_div(code[3:0]);
      2'b10:   code_to_div = fast_quad_div(code[3:0]);
      default: code_to_div = mid_quad_div(code[3:0]);
    endcase
  endfunction

  function automatic div_t half_of(input div_t d);
    half_of = d >> 1;
  endfunction

endpackage

// File: rtl/rate_code_regs.sv
module rate_code_regs
  import i2c_rate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  rate_code_t cfg_code,
  input  logic       bus_start,
  input  logic       xfer_busy,
  output rate_code_t act_code,
  output logic       div_change
);

  rate_code_t pend_code;
  logic       adopt;

  // adoption window: START / repeated START, or bus idle
  assign adopt      = bus_start | ~xfer_busy;
  assign div_change = adopt & (code_to_div(pend_code) != code_to_div(act_code));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_code <= '0;
      act_code  <= '0;
    end else begin
      if (cfg_we) pend_code <= cfg_code;
      if (adopt)  act_code  <= pend_code;
    end
  end

endmodule

// File: rtl/prescale_counter.sv
module prescale_counter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         strobe
);

  logic [W-1:0] count;
  logic [W-1:0] last;
  logic         wrap;

  assign last   = limit - W'(1);
  assign wrap   = (count >= last);
  assign strobe = run & (count == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               count <= '0;
    else if (!run || restart) count <= '0;
    else if (wrap)            count <= '0;
    else                      count <= count + W'(1);
  end

endmodule

// File: rtl/i2c_rate_prescaler.sv
module i2c_rate_prescaler
  import i2c_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_en,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_code,
  input  logic             bus_start,
  input  logic             xfer_busy,
  output logic             sample_tick,
  output logic             scl_strobe,
  output logic [DIV_W-1:0] active_div
);

  rate_code_t act_code;
  logic       div_change;
  div_t       limits  [NUM_STROBES];
  logic       strobes [NUM_STROBES];

  rate_code_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_code   (cfg_code),
    .bus_start  (bus_start),
    .xfer_busy  (xfer_busy),
    .act_code   (act_code),
    .div_change (div_change)
  );

  assign active_div = code_to_div(act_code);

  // index 0: full period (sample tick); index 1: half period (SCL)
  for (genvar g = 0; g < NUM_STROBES; g++) begin : g_cnt
    if (g == 0) begin : g_full
      assign limits[g] = active_div;
    end else begin : g_half
      assign limits[g] = half_of(active_div);
    end
    prescale_counter #(.W(DIV_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (blk_en),
      .restart (div_change),
      .limit   (limits[g]),
      .strobe  (strobes[g])
    );
  end

  assign sample_tick = strobes[0];
  assign scl_strobe  = strobes[1];

endmodule

// File: rtl/i2c_rate_prescaler_chk.sv
module i2c_rate_prescaler_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        blk_en,
  input logic        bus_start,
  input logic        xfer_busy,
  input logic        sample_tick,
  input logic        scl_strobe,
  input logic [11:0] active_div
);

  a_r2_div_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div >= 12'd22) && (active_div <= 12'd3840));

  a_r4_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> !sample_tick);

  a_r5_half_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |-> scl_strobe);

  a_r6_hold_in_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_busy && !bus_start) |=> $stable(active_div));

  a_r8_quiet_after_off: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en |=> !sample_tick && !scl_strobe);

  a_r9_restart_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    (active_div != $past(active_div)) |-> !sample_tick && !scl_strobe);

endmodule

bind i2c_rate_prescaler i2c_rate_prescaler_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk_en      (blk_en),
  .bus_start   (bus_start),
  .xfer_busy   (xfer_busy),
  .sample_tick (sample_tick),
  .scl_strobe  (scl_strobe),
  .active_div  (active_div)
);

// File: tb/i2c_rate_prescaler_test.sv
module i2c_rate_prescaler_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_code = '0;
  logic        bus_start = 1'b0;
  logic        xfer_busy = 1'b0;
  logic        sample_tick, scl_strobe;
  logic [11:0] active_div;

  always #10 clk = ~clk;

  i2c_rate_prescaler uut (
    .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .cfg_we(cfg_we),
    .cfg_code(cfg_code), .bus_start(bus_start), .xfer_busy(xfer_busy),
    .sample_tick(sample_tick), .scl_strobe(scl_strobe), .active_div(active_div)
  );

  int tab [64] = '{
    30, 32, 36, 42, 48, 52, 60, 72, 80, 88, 104, 128, 144, 160, 192, 240,
    288, 320, 384, 480, 576, 640, 768, 960, 1152, 1280, 1536, 1920, 2304, 2560, 3072, 3840,
    22, 24, 26, 28, 32, 36, 40, 44, 48, 56, 64, 72, 80, 96, 112, 128,
    160, 192, 224, 256, 320, 384, 448, 512, 640, 768, 896, 1024, 1280, 1536, 1792, 2048};

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  // behavioural reference state
  int m_pend = 0, m_act = 0, m_cnt = 0, m_hcnt = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 0; m_act = 0; m_cnt = 0; m_hcnt = 0;
    end else begin
      int d, h;
      bit adopt, restart;
      d = tab[m_act];
      h = d / 2;
      adopt   = bus_start || !xfer_busy;
      restart = !blk_en || (adopt && tab[m_pend] != tab[m_act]);
      m_cnt  = restart ? 0 : ((m_cnt  >= d - 1) ? 0 : m_cnt + 1);
      m_hcnt = restart ? 0 : ((m_hcnt >= h - 1) ? 0 : m_hcnt + 1);
      if (adopt)  m_act  = m_pend;
      if (cfg_we) m_pend = int'(cfg_code);
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int d;
      d = tab[m_act];
      check(int'(active_div) == d, "R2 active_div", int'(active_div), d);
      check(sample_tick == (blk_en && m_cnt == d - 1), "R4 sample_tick",
            int'(sample_tick), int'(blk_en && m_cnt == d - 1));
      check(scl_strobe == (blk_en && m_hcnt == d / 2 - 1), "R5 scl_strobe",
            int'(scl_strobe), int'(blk_en && m_hcnt == d / 2 - 1));
    end
  end

  task automatic finish_up();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below %0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
    end
  endtask

  task automatic write_code(input int c);
    @(posedge clk); #5;
    cfg_we = 1'b1; cfg_code = 6'(c);
    @(posedge clk); #5;
    cfg_we = 1'b0;
  endtask

  // cycles from the first negedge after the current one up to and including a tick
  task automatic cycles_to_tick(output int n);
    n = 0;
    for (int i = 0; i < 9000; i++) begin
      @(negedge clk);
      n++;
      if (sample_tick) return;
    end
  endtask

  task automatic period_check(input int code, input string req);
    int n, h, hc;
    write_code(code);
    step(2);
    cycles_to_tick(n);
    cycles_to_tick(n);
    check(n == tab[code], req, n, tab[code]);
    h = 0; hc = 0;
    for (int i = 0; i < tab[code]; i++) begin
      @(negedge clk);
      h++;
      if (scl_strobe) begin hc = h; break; end
    end
    check(hc == tab[code] / 2, "R5 half period", hc, tab[code] / 2);
  endtask

  initial begin
    int n;
    @(negedge clk); @(negedge clk);
    check(int'(active_div) == 30 && !sample_tick && !scl_strobe, "R1 reset state",
          int'(active_div), 30);
    #5 rst_n = 1'b1;
    blk_en = 1'b1;
    step(1);

    // R4/R5 default code, then one code from each quadrant
    cycles_to_tick(n);
    cycles_to_tick(n);
    check(n == 30, "R4 default period", n, 30);
    period_check(6'h03, "R4 quadrant0 period");
    period_check(6'h15, "R4 quadrant1 period");
    period_check(6'h2D, "R4 quadrant2 period");
    period_check(6'h3E, "R4 quadrant3 period");
    period_check(6'h1F, "R4 slowest period");
    period_check(6'h20, "R4 fastest period");

    // R2 every code while idle
    for (int c = 0; c < 64; c++) begin
      write_code(c);
      step(1);
      check(int'(active_div) == tab[c], "R2 table entry", int'(active_div), tab[c]);
    end

    // R6 write during a byte, R7 adoption at START, R9 restart
    write_code(6'h05);
    step(2);
    xfer_busy = 1'b1;
    write_code(6'h30);
    step(200);
    check(int'(active_div) == 52, "R6 held during byte", int'(active_div), 52);
    bus_start = 1'b1;
    @(posedge clk); #5;
    bus_start = 1'b0;
    check(int'(active_div) == 160, "R7 adopted at START", int'(active_div), 160);
    cycles_to_tick(n);
    check(n == 160, "R9 first tick after change", n, 160);
    xfer_busy = 1'b0;

    // R8 enable low, R3 code survives enable low
    write_code(6'h21);
    step(3);
    blk_en = 1'b0;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (sample_tick || scl_strobe) n++;
    end
    check(n == 0, "R8 no strobes while off", n, 0);
    check(int'(active_div) == 24, "R3 code kept while off", int'(active_div), 24);
    @(posedge clk); #5;
    blk_en = 1'b1;
    cycles_to_tick(n);
    check(n == 24, "R8 first tick after enable", n, 24);

    // R7 repeated START while busy with same divider: no restart
    xfer_busy = 1'b1;
    write_code(6'h21);
    bus_start = 1'b1;
    @(posedge clk); #5;
    bus_start = 1'b0;
    xfer_busy = 1'b0;
    step(60);
    finish_up();
  end

endmodule